// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the status of one DMA channel. A channel engine feeds it single-cycle event strobes: start, read-phase bus error, write-phase bus error, completion, and the read and write beat strobes of each transfer. It also drives level inputs for channel selection and the channel's live source address, destination address, remaining byte count and transfer size. From these the block keeps an 8-bit status byte that software can read at any time. The byte holds a configuration-error flag, two bus-error flags, request-pending, busy and done.

When a start arrives, the block checks the channel setup. It flags a configuration error if either address or the byte count is not a multiple of the transfer size, or if the count is zero. A bad setup ends the channel at once: done is set and busy stays clear. A good setup makes the channel busy. Software has a single action: writing 1 to the done bit clears done and all three error flags.

The block also drives the DMA acknowledge strobe. In one mode the strobe covers every cycle in which the channel is selected by an external request. In the other mode it covers only the beats of the final transfer. There is no data stream through this block, so every pin is a plain control or status signal.

Top module: `dma_chan_status`

## Requirements
- R1: After reset `status_o` reads 8'h00 and `ack_o` is low.
- R2: Status bits 7 and 3 always read 0. The bit layout is: 6 configuration error, 5 source (read) bus error, 4 destination (write) bus error, 2 request pending, 1 busy, 0 done.
- R3: A software write (`wr_en_i`) with `wr_data_i[0]`=0 changes nothing, whatever the other data bits hold.
- R4: `xfer_size_i` encodes 0=4 bytes, 1=1 byte, 2=2 bytes, 3=16 bytes. A start while idle whose source address, destination address or byte count is not a multiple of that size sets configuration error (bit 6) and done (bit 0) on the next edge, and busy stays 0.
- R5: A start while idle with a byte count of zero sets configuration error and done on the next edge, and busy stays 0.
- R6: A start while idle with a valid setup sets busy (bit 1) on the next edge. Done and the error flags are left unchanged.
- R7: Request pending (bit 2) reads 1 exactly when busy is 1, `chan_sel_i` is 0 and the byte count is nonzero. It drops in the same cycle that `chan_sel_i` rises.
- R8: A read-phase bus error while busy sets bit 5 and done, and clears busy, on the next edge.
- R9: A write-phase bus error while busy sets bit 4 and done, and clears busy, on the next edge.
- R10: A completion strobe while busy sets done and clears busy on the next edge.
- R11: A write with `wr_data_i[0]`=1 clears done, configuration error and both bus-error flags on the next edge.
- R12: If a hardware event sets a flag in the same cycle as a clearing write, the flag ends up set.
- R13: With `ack_type_i`=0, `ack_o` equals `chan_sel_i` AND `sel_ext_i` in the same cycle, with or without beat strobes.
- R14: With `ack_type_i`=1, `ack_o` is high only while the channel is selected by an external request, the byte count equals one transfer's size, and a read or write beat strobe is present. In dual-address mode this gives the strobe on both the read and the write beat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition strobe |
| chan_sel_i | input | 1 | Channel currently selected (level) |
| sel_ext_i | input | 1 | Current selection came from an external request |
| rd_err_i | input | 1 | Bus error on read portion strobe |
| wr_err_i | input | 1 | Bus error on write portion strobe |
| beat_rd_i | input | 1 | Read beat of a transfer |
| beat_wr_i | input | 1 | Write beat of a transfer |
| cmpl_i | input | 1 | Normal completion strobe |
| src_addr_i | input | AW | Current source address |
| dst_addr_i | input | AW | Current destination address |
| byte_cnt_i | input | CW | Remaining byte count |
| xfer_size_i | input | 2 | Transfer size code |
| ack_type_i | input | 1 | 0: acknowledge every selected cycle, 1: final transfer only |
| wr_en_i | input | 1 | Software write to the status byte |
| wr_data_i | input | 8 | Software write data |
| status_o | output | 8 | Status byte |
| ack_o | output | 1 | DMA acknowledge |

## Verification
A flag register stuck or wrongly cleared shows on `status_o` one edge after the event that should have moved it. Any event therefore has to be followed by a read in the very next cycle. Request pending and the acknowledge are combinational, so a wrong decode of selection, the final count or the mode shows in the same cycle the inputs change. A misdecoded transfer size appears only as a wrong configuration-error result at start. Each size code is therefore driven with a misaligned field at least once.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int BIT_DONE = 0;
  localparam int BIT_BUSY = 1;
  localparam int BIT_REQ  = 2;
  localparam int BIT_BED  = 4;
  localparam int BIT_BES  = 5;
  localparam int BIT_CE   = 6;

  typedef enum logic [1:0] {
    SZ_WORD = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_LINE = 2'd3
  } xfer_size_e;

  // low bits that must be zero for a given size
  function automatic logic [3:0] align_mask(input logic [1:0] sz);
    case (xfer_size_e'(sz))
      SZ_WORD: align_mask = 4'b0011;
      SZ_BYTE: align_mask = 4'b0000;
      SZ_HALF: align_mask = 4'b0001;
      default: align_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [4:0] size_bytes(input logic [1:0] sz);
    size_bytes = {1'b0, align_mask(sz)} + 5'd1;
  endfunction
endpackage

// File: rtl/dcs_cfg_check.sv
module dcs_cfg_check #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [1:0]    xfer_size_i,
  output logic          cfg_bad_o,
  output logic          last_o
);
  import dcs_pkg::*;
  localparam int PAD = CW - 5;

  logic [3:0] mask;
  logic       mis_src, mis_dst, mis_cnt, cnt_zero;

  always_comb begin
    mask     = align_mask(xfer_size_i);
    mis_src  = |(src_addr_i[3:0] & mask);
    mis_dst  = |(dst_addr_i[3:0] & mask);
    mis_cnt  = |(byte_cnt_i[3:0] & mask);
    cnt_zero = (byte_cnt_i == '0);
    cfg_bad_o = mis_src | mis_dst | mis_cnt | cnt_zero;
    last_o    = (byte_cnt_i == {{PAD{1'b0}}, size_bytes(xfer_size_i)});
  end
endmodule

// File: rtl/dcs_ack_gen.sv
module dcs_ack_gen (
  input  logic chan_sel_i,
  input  logic sel_ext_i,
  input  logic ack_type_i,
  input  logic last_i,
  input  logic beat_rd_i,
  input  logic beat_wr_i,
  output logic ack_o
);
  logic ext_sel;
  always_comb begin
    ext_sel = chan_sel_i & sel_ext_i;
    if (ack_type_i) ack_o = ext_sel & last_i & (beat_rd_i | beat_wr_i);
    else            ack_o = ext_sel;
  end
endmodule

// File: rtl/dcs_flags.sv
module dcs_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic cfg_bad_i,
  input  logic rd_err_i,
  input  logic wr_err_i,
  input  logic cmpl_i,
  input  logic sw_clr_i,
  output logic busy_o,
  output logic done_o,
  output logic ce_o,
  output logic bes_o,
  output logic bed_o
);
  logic busy_n, done_n, ce_n, bes_n, bed_n;

  always_comb begin
    busy_n = busy_o;
    done_n = done_o;
    ce_n   = ce_o;
    bes_n  = bes_o;
    bed_n  = bed_o;
    // software clear first; hardware sets below override it
    if (sw_clr_i) begin
      done_n = 1'b0;
      ce_n   = 1'b0;
      bes_n  = 1'b0;
      bed_n  = 1'b0;
    end
    if (!busy_o && start_i) begin
      if (cfg_bad_i) begin
        ce_n   = 1'b1;
        done_n = 1'b1;
      end else begin
        busy_n = 1'b1;
      end
    end
    if (busy_o) begin
      if (rd_err_i) begin
        bes_n  = 1'b1;
        done_n = 1'b1;
        busy_n = 1'b0;
      end
      if (wr_err_i) begin
        bed_n  = 1'b1;
        done_n = 1'b1;
        busy_n = 1'b0;
      end
      if (cmpl_i) begin
        done_n = 1'b1;
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      ce_o   <= 1'b0;
      bes_o  <= 1'b0;
      bed_o  <= 1'b0;
    end else begin
      busy_o <= busy_n;
      done_o <= done_n;
      ce_o   <= ce_n;
      bes_o  <= bes_n;
      bed_o  <= bed_n;
    end
  end
endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          chan_sel_i,
  input  logic          sel_ext_i,
  input  logic          rd_err_i,
  input  logic          wr_err_i,
  input  logic          beat_rd_i,
  input  logic          beat_wr_i,
  input  logic          cmpl_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [CW-1:0] byte_cnt_i,
  input  logic [1:0]    xfer_size_i,
  input  logic          ack_type_i,
  input  logic          wr_en_i,
  input  logic [7:0]    wr_data_i,
  output logic [7:0]    status_o,
  output logic          ack_o
);
  import dcs_pkg::*;

  logic cfg_bad, last_xfer, sw_clr;
  logic busy, done, ce, bes, bed, req;

  assign sw_clr = wr_en_i & wr_data_i[BIT_DONE];

  dcs_cfg_check #(.AW(AW), .CW(CW)) u_cfg (
    .src_addr_i (src_addr_i),
    .dst_addr_i (dst_addr_i),
    .byte_cnt_i (byte_cnt_i),
    .xfer_size_i(xfer_size_i),
    .cfg_bad_o  (cfg_bad),
    .last_o     (last_xfer)
  );

  dcs_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .cfg_bad_i(cfg_bad),
    .rd_err_i (rd_err_i),
    .wr_err_i (wr_err_i),
    .cmpl_i   (cmpl_i),
    .sw_clr_i (sw_clr),
    .busy_o   (busy),
    .done_o   (done),
    .ce_o     (ce),
    .bes_o    (bes),
    .bed_o    (bed)
  );

  dcs_ack_gen u_ack (
    .chan_sel_i(chan_sel_i),
    .sel_ext_i (sel_ext_i),
    .ack_type_i(ack_type_i),
    .last_i    (last_xfer),
    .beat_rd_i (beat_rd_i),
    .beat_wr_i (beat_wr_i),
    .ack_o     (ack_o)
  );

  assign req = busy & ~chan_sel_i & (byte_cnt_i != '0);

  always_comb begin
    status_o           = 8'h00;
    status_o[BIT_CE]   = ce;
    status_o[BIT_BES]  = bes;
    status_o[BIT_BED]  = bed;
    status_o[BIT_REQ]  = req;
    status_o[BIT_BUSY] = busy;
    status_o[BIT_DONE] = done;
  end
endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          chan_sel_i,
  input logic          sel_ext_i,
  input logic          rd_err_i,
  input logic          wr_err_i,
  input logic          cmpl_i,
  input logic [CW-1:0] byte_cnt_i,
  input logic [1:0]    xfer_size_i,
  input logic          ack_type_i,
  input logic          wr_en_i,
  input logic [7:0]    wr_data_i,
  input logic [7:0]    status_o,
  input logic          ack_o
);
  logic [CW-1:0] one_xfer;
  always_comb begin
    case (xfer_size_i)
      2'd0:    one_xfer = CW'(4);
      2'd1:    one_xfer = CW'(1);
      2'd2:    one_xfer = CW'(2);
      default: one_xfer = CW'(16);
    endcase
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] == 1'b0) && (status_o[3] == 1'b0)); // R2
  AST_ZERO_CNT_CE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !status_o[1] && byte_cnt_i == '0 |=> status_o[6] && status_o[0] && !status_o[1]); // R5
  AST_RD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_i && status_o[1] |=> status_o[5] && status_o[0] && !status_o[1]); // R8
  AST_WR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_i && status_o[1] |=> status_o[4] && status_o[0] && !status_o[1]); // R9
  AST_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_i && status_o[1] |=> status_o[0] && !status_o[1]); // R10
  AST_REQ_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    chan_sel_i |-> !status_o[2]); // R7
  AST_SW_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i && wr_data_i[0] && !start_i && !rd_err_i && !wr_err_i && !cmpl_i
    |=> status_o[6:4] == 3'b000 && !status_o[0]); // R11
  AST_ACK_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_type_i && ack_o |-> byte_cnt_i == one_xfer && chan_sel_i && sel_ext_i); // R14
  AST_ACK_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_type_i |-> ack_o == (chan_sel_i && sel_ext_i)); // R13
endmodule

bind dma_chan_status dcs_checker #(.CW(CW)) u_dcs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .chan_sel_i (chan_sel_i),
  .sel_ext_i  (sel_ext_i),
  .rd_err_i   (rd_err_i),
  .wr_err_i   (wr_err_i),
  .cmpl_i     (cmpl_i),
  .byte_cnt_i (byte_cnt_i),
  .xfer_size_i(xfer_size_i),
  .ack_type_i (ack_type_i),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .status_o   (status_o),
  .ack_o      (ack_o)
);

// File: tb/sim_dma_chan_status.sv
module sim_dma_chan_status;
  localparam int AW = 32;
  localparam int CW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, chan_sel_i = 0, sel_ext_i = 0, rd_err_i = 0, wr_err_i = 0;
  logic beat_rd_i = 0, beat_wr_i = 0, cmpl_i = 0, ack_type_i = 0, wr_en_i = 0;
  logic [AW-1:0] src_addr_i = '0, dst_addr_i = '0;
  logic [CW-1:0] byte_cnt_i = '0;
  logic [1:0]    xfer_size_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic [7:0]    status_o;
  logic          ack_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_chan_status #(.AW(AW), .CW(CW)) u0 (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs after a falling edge, take one rising edge, sample 1 ns later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1; wr_data_i = d;
    tick();
    wr_en_i = 0; wr_data_i = 0;
  endtask

  task automatic do_start(input logic [1:0] sz, input logic [AW-1:0] s,
                          input logic [AW-1:0] d, input logic [CW-1:0] n);
    @(negedge clk);
    xfer_size_i = sz; src_addr_i = s; dst_addr_i = d; byte_cnt_i = n;
    start_i = 1;
    tick();
    start_i = 0;
  endtask

  task automatic pulse_cmpl();
    @(negedge clk); cmpl_i = 1; tick(); cmpl_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h00);
    chk("R1 ack", {7'd0, ack_o}, 8'h00);
  endtask

  task automatic t_write_ignored();
    sw_write(8'hFE);
    chk("R3 write without done bit", status_o, 8'h00);
    sw_write(8'hFF);
    chk("R2 reserved bits after write", status_o & 8'h88, 8'h00);
  endtask

  task automatic t_normal_run();
    do_start(2'd0, 32'h100, 32'h200, 24'h40);
    chk("R6 busy with request", status_o, 8'h06);
    @(negedge clk); chan_sel_i = 1; #1;
    chk("R7 request drops on select", status_o, 8'h02);
    chan_sel_i = 0; #1;
    chk("R7 request back when deselected", status_o, 8'h06);
    pulse_cmpl();
    chk("R10 completion", status_o, 8'h01);
    sw_write(8'h01);
    chk("R11 clear after completion", status_o, 8'h00);
  endtask

  task automatic t_cfg_errors();
    do_start(2'd0, 32'h102, 32'h200, 24'h40);
    chk("R4 word src misaligned", status_o, 8'h41);
    sw_write(8'h01);
    chk("R11 clears config error", status_o, 8'h00);
    do_start(2'd2, 32'h100, 32'h201, 24'h40);
    chk("R4 half dst misaligned", status_o, 8'h41);
    sw_write(8'h01);
    do_start(2'd3, 32'h100, 32'h200, 24'h18);
    chk("R4 line count misaligned", status_o, 8'h41);
    sw_write(8'h01);
    do_start(2'd1, 32'h101, 32'h203, 24'h0);
    chk("R5 zero count", status_o, 8'h41);
    sw_write(8'h01);
  endtask

  task automatic t_bus_errors();
    do_start(2'd1, 32'h101, 32'h203, 24'h3);
    chk("R6 byte size odd address accepted", status_o, 8'h06);
    @(negedge clk); rd_err_i = 1; tick(); rd_err_i = 0;
    chk("R8 read bus error", status_o, 8'h21);
    sw_write(8'h7E);
    chk("R3 write leaves flags", status_o, 8'h21);
    sw_write(8'h01);
    chk("R11 clears source error", status_o, 8'h00);
    do_start(2'd2, 32'h100, 32'h200, 24'h10);
    @(negedge clk); wr_err_i = 1; tick(); wr_err_i = 0;
    chk("R9 write bus error", status_o, 8'h11);
    sw_write(8'h01);
  endtask

  task automatic t_collision();
    do_start(2'd0, 32'h100, 32'h200, 24'h40);
    @(negedge clk); cmpl_i = 1; wr_en_i = 1; wr_data_i = 8'h01;
    tick();
    cmpl_i = 0; wr_en_i = 0; wr_data_i = 0;
    chk("R12 completion beats clear", status_o, 8'h01);
    sw_write(8'h01);
  endtask

  task automatic t_ack();
    @(negedge clk);
    ack_type_i = 0; chan_sel_i = 1; sel_ext_i = 1; #1;
    chk("R13 ack on external select", {7'd0, ack_o}, 8'h01);
    sel_ext_i = 0; #1;
    chk("R13 no ack on internal select", {7'd0, ack_o}, 8'h00);
    ack_type_i = 1; sel_ext_i = 1; xfer_size_i = 2'd0; byte_cnt_i = 24'd8; beat_rd_i = 1; #1;
    chk("R14 no ack before final", {7'd0, ack_o}, 8'h00);
    byte_cnt_i = 24'd4; #1;
    chk("R14 ack final read", {7'd0, ack_o}, 8'h01);
    beat_rd_i = 0; beat_wr_i = 1; #1;
    chk("R14 ack final write", {7'd0, ack_o}, 8'h01);
    beat_wr_i = 0; #1;
    chk("R14 no ack without beat", {7'd0, ack_o}, 8'h00);
    chan_sel_i = 0; sel_ext_i = 0; ack_type_i = 0;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    t_write_ignored();
    t_normal_run();
    t_cfg_errors();
    t_bus_errors();
    t_collision();
    t_ack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule